// File: doc/BRIEF.md
# Conditional Sum Adder

A K-bit binary adder that resolves carries by repeated selection rather than by rippling or by a carry lookahead tree. Every bit position first forms two candidate (sum, carry) pairs: one for an incoming carry of 0 and one for an incoming carry of 1. The design then runs log2(K) merge levels, and each level joins neighbouring groups into groups of twice the size. At each merge, the lower group's conditional carry, taken under either assumption, picks the matching candidate of the upper group. The lower bits then pass through unchanged, next to the selected upper bits.

After the last merge, one group spans the whole word and still holds both candidates. The actual carry-in picks between them and gives the sum and the carry-out. The block is purely combinational. The width K must be a power of two. A width that is not a power of two stops elaboration.

Top module: `cond_sum_adder`

## Requirements
- R1: For all inputs, the concatenation {cout, sum} equals the unsigned value a + b + cin taken as a K+1 bit number.
- R2: With b equal to zero and cin equal to 0, sum equals a and cout is 0.
- R3: With a all ones, b zero and cin 1, the carry travels across every bit: sum is all zeros and cout is 1.
- R4: cout is 1 exactly when a + b + cin is at least 2^K.
- R5: Swapping the operands a and b leaves sum and cout unchanged.
- R6: With a and b both all ones and cin 1, sum is all ones and cout is 1.
- R7: Bit 0 of sum always equals a[0] xor b[0] xor cin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | K | First operand, unsigned |
| b | input | K | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | K | Low K bits of a + b + cin |
| cout | output | 1 | Carry out of bit K-1 |

## Verification
Both results are combinational, so sum and cout are due in the same cycle in which the operands are applied. No register stands between inputs and outputs, and a result therefore has a latency of zero cycles. The bench drives the inputs just after a rising edge and compares the outputs at the following falling edge, by which point the selection network has settled. Three widths are covered: a 4-bit instance tested with every input combination, and 16-bit and 32-bit instances tested with corner patterns and random vectors.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // one conditional result of a bit or group position
  typedef struct packed {
    logic s;
    logic c;
  } csa_pair_t;

  function automatic bit csa_is_pow2(input int n);
    return (n > 0) && ((n & (n - 1)) == 0);
  endfunction

endpackage

// File: rtl/csa_bit_cell.sv
module csa_bit_cell
  import csa_pkg::*;
(
  input  logic      x,
  input  logic      y,
  output csa_pair_t r_c0,
  output csa_pair_t r_c1
);

  logic hx;

  assign hx     = x ^ y;
  // assumed incoming carry 0
  assign r_c0.s = hx;
  assign r_c0.c = x & y;
  // assumed incoming carry 1
  assign r_c1.s = ~hx;
  assign r_c1.c = x | y;

endmodule

// File: rtl/csa_merge_level.sv
module csa_merge_level #(
  parameter int K = 16,
  parameter int G = 1
) (
  input  logic [K-1:0]         s0_i,
  input  logic [K-1:0]         s1_i,
  input  logic [K/G-1:0]       c0_i,
  input  logic [K/G-1:0]       c1_i,
  output logic [K-1:0]         s0_o,
  output logic [K-1:0]         s1_o,
  output logic [K/(2*G)-1:0]   c0_o,
  output logic [K/(2*G)-1:0]   c1_o
);

  localparam int NGO = K / (2 * G);

  for (genvar m = 0; m < NGO; m++) begin : g_pair
    localparam int LO = 2 * m * G;
    localparam int HI = LO + G;
    logic pick0, pick1;

    // lower group's carry under each assumption steers the upper group
    assign pick0 = c0_i[2*m];
    assign pick1 = c1_i[2*m];

    assign s0_o[LO +: G] = s0_i[LO +: G];
    assign s1_o[LO +: G] = s1_i[LO +: G];

    assign s0_o[HI +: G] = pick0 ? s1_i[HI +: G] : s0_i[HI +: G];
    assign s1_o[HI +: G] = pick1 ? s1_i[HI +: G] : s0_i[HI +: G];

    assign c0_o[m] = pick0 ? c1_i[2*m+1] : c0_i[2*m+1];
    assign c1_o[m] = pick1 ? c1_i[2*m+1] : c0_i[2*m+1];
  end

endmodule

// File: rtl/csa_final_select.sv
module csa_final_select #(
  parameter int K = 16
) (
  input  logic [K-1:0] s0_i,
  input  logic [K-1:0] s1_i,
  input  logic         c0_i,
  input  logic         c1_i,
  input  logic         cin,
  output logic [K-1:0] sum,
  output logic         cout
);

  assign sum  = cin ? s1_i : s0_i;
  assign cout = cin ? c1_i : c0_i;

endmodule

// File: rtl/cond_sum_adder.sv
module cond_sum_adder
  import csa_pkg::*;
#(
  parameter int K = 16
) (
  input  logic [K-1:0] a,
  input  logic [K-1:0] b,
  input  logic         cin,
  output logic [K-1:0] sum,
  output logic         cout
);

  localparam int LV = $clog2(K);

  if (!csa_is_pow2(K)) begin : g_bad_width
    $error("cond_sum_adder: K must be a power of two");
  end

  // per level candidate sums and group carries (low K>>l bits valid)
  logic [K-1:0] s0_w [LV+1];
  logic [K-1:0] s1_w [LV+1];
  logic [K-1:0] c0_w [LV+1];
  logic [K-1:0] c1_w [LV+1];

  for (genvar i = 0; i < K; i++) begin : g_cell
    csa_pair_t p0, p1;
    csa_bit_cell u_cell (
      .x    (a[i]),
      .y    (b[i]),
      .r_c0 (p0),
      .r_c1 (p1)
    );
    assign s0_w[0][i] = p0.s;
    assign c0_w[0][i] = p0.c;
    assign s1_w[0][i] = p1.s;
    assign c1_w[0][i] = p1.c;
  end

  for (genvar l = 0; l < LV; l++) begin : g_level
    localparam int GI  = 1 << l;
    localparam int NGI = K >> l;
    localparam int NGO = K >> (l + 1);

    csa_merge_level #(.K(K), .G(GI)) u_merge (
      .s0_i (s0_w[l]),
      .s1_i (s1_w[l]),
      .c0_i (c0_w[l][NGI-1:0]),
      .c1_i (c1_w[l][NGI-1:0]),
      .s0_o (s0_w[l+1]),
      .s1_o (s1_w[l+1]),
      .c0_o (c0_w[l+1][NGO-1:0]),
      .c1_o (c1_w[l+1][NGO-1:0])
    );

    assign c0_w[l+1][K-1:NGO] = '0;
    assign c1_w[l+1][K-1:NGO] = '0;
  end

  csa_final_select #(.K(K)) u_final (
    .s0_i (s0_w[LV]),
    .s1_i (s1_w[LV]),
    .c0_i (c0_w[LV][0]),
    .c1_i (c1_w[LV][0]),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
  );

endmodule

// File: rtl/cond_sum_adder_chk.sv
module cond_sum_adder_chk #(
  parameter int K = 16
) (
  input logic [K-1:0] a,
  input logic [K-1:0] b,
  input logic         cin,
  input logic [K-1:0] sum,
  input logic         cout
);

  logic [K:0] ref_total;

  always_comb begin
    ref_total = {1'b0, a} + {1'b0, b} + {{K{1'b0}}, cin};
    AST_FULL_SUM: assert ({cout, sum} == ref_total) else $error("full sum mismatch"); // R1
    AST_ZERO_ADDEND: assert (!((b == '0) && !cin) || ((sum == a) && !cout)) else $error("zero addend"); // R2
    AST_FULL_PROPAGATE: assert (!((a == '1) && (b == '0) && cin) || ((sum == '0) && cout)) else $error("propagate"); // R3
    AST_CARRY_OUT: assert (cout == ref_total[K]) else $error("carry out"); // R4
    AST_ALL_ONES: assert (!((a == '1) && (b == '1) && cin) || ((sum == '1) && cout)) else $error("all ones"); // R6
    AST_LSB_PARITY: assert (sum[0] == (a[0] ^ b[0] ^ cin)) else $error("lsb parity"); // R7
  end

endmodule

bind cond_sum_adder cond_sum_adder_chk #(.K(K)) u_chk (
  .a    (a),
  .b    (b),
  .cin  (cin),
  .sum  (sum),
  .cout (cout)
);

// File: tb/cond_sum_adder_test.sv
module cond_sum_adder_test;

  localparam int CLK_PERIOD = 10;

  logic clk;
  logic rst_n;
  int   total;
  int   bad;

  logic [15:0] a16, b16, s16;
  logic        ci16, co16;
  logic [3:0]  a4, b4, s4;
  logic        ci4, co4;
  logic [31:0] a32, b32, s32;
  logic        ci32, co32;

  cond_sum_adder #(.K(16)) uut (
    .a(a16), .b(b16), .cin(ci16), .sum(s16), .cout(co16)
  );
  cond_sum_adder #(.K(4)) uut4 (
    .a(a4), .b(b4), .cin(ci4), .sum(s4), .cout(co4)
  );
  cond_sum_adder #(.K(32)) uut32 (
    .a(a32), .b(b32), .cin(ci32), .sum(s32), .cout(co32)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report(input string rq, input logic [32:0] act, input logic [32:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic chk16(input logic [15:0] x, input logic [15:0] y, input logic c, input string rq);
    logic [16:0] e;
    @(posedge clk);
    a16 <= x; b16 <= y; ci16 <= c;
    @(negedge clk);
    e = {1'b0, x} + {1'b0, y} + {16'd0, c};
    report(rq, {16'd0, co16, s16}, {16'd0, e});
  endtask

  task automatic chk4(input logic [3:0] x, input logic [3:0] y, input logic c, input string rq);
    logic [4:0] e;
    @(posedge clk);
    a4 <= x; b4 <= y; ci4 <= c;
    @(negedge clk);
    e = {1'b0, x} + {1'b0, y} + {4'd0, c};
    report(rq, {28'd0, co4, s4}, {28'd0, e});
  endtask

  task automatic chk32(input logic [31:0] x, input logic [31:0] y, input logic c, input string rq);
    logic [32:0] e;
    @(posedge clk);
    a32 <= x; b32 <= y; ci32 <= c;
    @(negedge clk);
    e = {1'b0, x} + {1'b0, y} + {32'd0, c};
    report(rq, {co32, s32}, e);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0;
    bad   = 0;
    rst_n = 1'b0;
    a16 = '0; b16 = '0; ci16 = 1'b0;
    a4  = '0; b4  = '0; ci4  = 1'b0;
    a32 = '0; b32 = '0; ci32 = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // quiet state: all-zero inputs give zero outputs (R2)
    @(negedge clk);
    report("R2 idle", {16'd0, co16, s16}, 33'd0);

    // R2: zero addend passes a through
    chk16(16'hBEEF, 16'h0000, 1'b0, "R2");
    report("R2 pass", {16'd0, co16, s16}, {17'd0, 16'hBEEF});
    // R3: full propagation, 16 and 32 bit
    chk16(16'hFFFF, 16'h0000, 1'b1, "R3");
    report("R3 w16", {16'd0, co16, s16}, {16'd0, 1'b1, 16'h0000});
    chk32(32'hFFFF_FFFF, 32'h0, 1'b1, "R3");
    report("R3 w32", {co32, s32}, {1'b1, 32'h0});
    // R6: all ones plus all ones plus one
    chk16(16'hFFFF, 16'hFFFF, 1'b1, "R6");
    report("R6 w16", {16'd0, co16, s16}, {16'd0, 1'b1, 16'hFFFF});
    chk32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R6");
    // R4: carry-out boundary, exactly 2^K and one below
    chk16(16'h8000, 16'h7FFF, 1'b1, "R4 at 2^K");
    report("R4 edge", {32'd0, co16}, 33'd1);
    chk16(16'h8000, 16'h7FFF, 1'b0, "R4 below 2^K");
    report("R4 below", {32'd0, co16}, 33'd0);
    // alternating patterns for group boundaries
    chk16(16'hAAAA, 16'h5555, 1'b1, "R1 alt");
    chk16(16'h00FF, 16'h0001, 1'b0, "R1 byte carry");
    chk32(32'h0000_FFFF, 32'h0000_0001, 1'b0, "R1 half carry");

    // R5: operand swap
    for (int n = 0; n < 200; n++) begin
      logic [15:0] x, y;
      logic [16:0] r1;
      x = 16'($urandom);
      y = 16'($urandom);
      chk16(x, y, n[0], "R5 fwd");
      r1 = {co16, s16};
      chk16(y, x, n[0], "R5 rev");
      report("R5 swap", {16'd0, co16, s16}, {16'd0, r1});
    end

    // R1, R4, R7: exhaustive 4-bit
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        for (int c = 0; c < 2; c++) begin
          chk4(4'(x), 4'(y), c[0], "R1 exhaustive w4");
          report("R7 lsb", {32'd0, s4[0]}, {32'd0, 1'(x ^ y ^ c)});
        end
      end
    end

    // R1: random 16 and 32 bit
    for (int n = 0; n < 1500; n++) begin
      chk16(16'($urandom), 16'($urandom), 1'($urandom), "R1 random w16");
      chk32($urandom, $urandom, 1'($urandom), "R1 random w32");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule